// File: doc/BRIEF.md
# Channel Fault Filter and Diagnosis Encoder

This block sits between the per-channel fault detectors of a two-channel low-side driver and the pins and registers that report on them. It receives raw indications for short to ground, open load or under current, overload and over-temperature, plus the IC over-temperature warning. Every fault except over-temperature has to persist for a programmable number of clock cycles before it counts. The block then reports these faults in one of two ways, chosen by a mode bit.

In status-pin mode each channel has an unlatched status output. It copies the channel's command while the channel is healthy and shows the inverted command while a recognized fault is present. In serial mode the faults are held in latched flags. Any held channel flag pulls an active-low fault output low. The flags are cleared by a one-cycle strobe that the serial interface raises after a valid transfer. Two cases refuse the clear while the channel is still commanded on: overload in latched-shutdown mode and over-temperature in latched mode. In both modes the block maintains an 8-bit diagnosis word with a prioritized 2-bit code per channel, an over-temperature summary bit and the IC warning bit. Sleep silences the outputs and stops fault collection.

Top module: `diag_encoder`

## Requirements
- R1: While reset is asserted and at the first clock after it, the diagnosis word reads FFh, fault_n is high and no flag is held.
- R2: Short to ground, open load/under current and overload on a channel are recognized only once the raw input has been high at FILT_CYCLES consecutive clock edges. A shorter pulse changes no status pin, flag, fault_n or diagnosis bit.
- R3: Over-temperature is not filtered. It inverts the status pin in the same cycle and sets its flag at the next clock edge.
- R4: In status-pin mode (serial_mode = 0) status_o[c] equals ch_cmd[c] with no recognized fault and its inverse while one is present. It returns to ch_cmd[c] as soon as the fault goes away. In serial mode status_o reads 0.
- R5: The diagnosis word is updated at the same edge as the flags. Bits 7:6 are 1. Bits 5:4 carry the code of channel index 1 and bits 3:2 the code of channel index 0. Codes are 00 short to ground, 01 open load/under current, 10 overload or over-temperature, 11 no fault. Bit 1 is 1 while either channel holds an over-temperature flag, and bit 0 is 1 while the IC warning flag is held.
- R6: With several flags on one channel the code follows the priority overload/over-temperature, then short to ground, then open load/under current.
- R7: Flags stay set after their fault disappears. fault_n is low exactly when serial_mode = 1, sleep = 0 and at least one channel flag is held. In status-pin mode fault_n is high.
- R8: At a clock edge with clr_stb high, each clearable flag takes the present state of its recognized fault. A fault that is still present therefore keeps its flag set.
- R9: When ovl_latch = 1 the overload flag, and when ot_latch = 1 the over-temperature flag, ignore clr_stb while ch_cmd of that channel is 1. Once the command is 0 the clear takes effect.
- R10: With sleep = 1, status_o is 0 and fault_n is high. Filter counters are held at zero, flags keep their values, and raw faults in this period leave no trace.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sleep | input | 1 | Low-power state, silences diagnostics |
| serial_mode | input | 1 | 0 = status pins, 1 = latched flags and fault pin |
| clr_stb | input | 1 | One-cycle clear after a valid serial transfer |
| ovl_latch | input | 1 | 1 = overload shuts the channel down and latches |
| ot_latch | input | 1 | 1 = over-temperature latches instead of restarting |
| ch_cmd | input | 2 | Resolved on/off command per channel |
| raw_sg | input | 2 | Raw short-to-ground indication per channel |
| raw_ol | input | 2 | Raw open-load / under-current indication per channel |
| raw_ovl | input | 2 | Raw overload indication per channel |
| raw_ot | input | 2 | Raw channel over-temperature indication |
| ic_warn | input | 1 | IC over-temperature warning |
| status_o | output | 2 | Unlatched status pin per channel |
| fault_n | output | 1 | Active-low summary of held channel flags |
| diag_word | output | 8 | Diagnosis word |

## Verification
The bench targets the filter boundary. A pulse one edge shorter than the filter window must leave no trace, and one of exactly the window length must be recognized. A design that counts off by one would either report glitches or miss faults at that length. It also exercises a clear that arrives while a fault persists, where a faulty design would briefly show a healthy code. The clear is also tried in the latched overload and over-temperature cases with the channel still commanded on, where a faulty design would let a shut-down channel restart. The bench stacks faults to test code priority. It also checks that raw faults during sleep are lost and that the over-temperature path bypasses the filter. A random phase compares every cycle against a bench model.

// File: rtl/diag_pkg.sv
// Shared types for the diagnosis encoder: per-channel flag bundle, the
// 2-bit channel code and the priority function that selects it.
// Assumes two channels so that the diagnosis word fits in eight bits.
package diag_pkg;

    localparam int unsigned NCH     = 2;
    localparam int unsigned WORD_W  = 8;
    localparam int unsigned NFILT   = 3;   // filtered fault kinds per channel

    typedef enum logic [1:0] {
        CODE_SHORT = 2'b00,
        CODE_OPEN  = 2'b01,
        CODE_PROT  = 2'b10,
        CODE_OK    = 2'b11
    } diag_code_e;

    typedef struct packed {
        logic ovl;   // overload
        logic ot;    // channel over-temperature
        logic sg;    // short to ground
        logic ol;    // open load or under current
    } chan_flags_t;

    // Protective faults win over short to ground, which wins over open load.
    function automatic diag_code_e pick_code(input chan_flags_t f);
        if (f.ovl || f.ot) return CODE_PROT;
        if (f.sg)          return CODE_SHORT;
        if (f.ol)          return CODE_OPEN;
        return CODE_OK;
    endfunction

endpackage

// File: rtl/fault_filter.sv
// Minimum-duration filter for one raw fault line.
// The output goes high once the raw line has been high at FILT_CYCLES
// consecutive clock edges and drops at the first edge that sees it low.
// Assumes FILT_CYCLES >= 1. The quiet input holds the counter at zero.
module fault_filter #(
    parameter int unsigned FILT_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic quiet,
    input  logic raw,
    output logic filt
);
    localparam int unsigned   CW    = $clog2(FILT_CYCLES + 1);
    localparam logic [CW-1:0] LIMIT = CW'(FILT_CYCLES);

    logic [CW-1:0] cnt_q;

    // Count consecutive high samples, saturating at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n)               cnt_q <= '0;
        else if (quiet || !raw)   cnt_q <= '0;
        else if (cnt_q != LIMIT)  cnt_q <= cnt_q + 1'b1;
    end

    assign filt = (cnt_q == LIMIT);

endmodule

// File: rtl/chan_flags.sv
// Latched diagnosis flags of one channel.
// Flags accumulate the live (recognized) faults. A clear strobe reloads
// each flag with its live value, except that a latched overload or a
// latched over-temperature flag keeps its value while the channel is
// commanded on. Nothing changes while frozen (sleep).
module chan_flags (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  freeze,
    input  logic                  clr,
    input  logic                  cmd,
    input  logic                  ovl_latched,
    input  logic                  ot_latched,
    input  diag_pkg::chan_flags_t live,
    output diag_pkg::chan_flags_t flags_q,
    output diag_pkg::chan_flags_t flags_d
);
    import diag_pkg::*;

    logic keep_ovl;
    logic keep_ot;

    // Decide whether a clear is refused for the latched protective flags.
    always_comb begin
        keep_ovl = ovl_latched && cmd;
        keep_ot  = ot_latched  && cmd;
    end

    // Next flag state: accumulate, or reload on a permitted clear.
    always_comb begin
        flags_d = flags_q;
        if (!freeze) begin
            if (clr) begin
                flags_d.sg  = live.sg;
                flags_d.ol  = live.ol;
                flags_d.ovl = keep_ovl ? (flags_q.ovl | live.ovl) : live.ovl;
                flags_d.ot  = keep_ot  ? (flags_q.ot  | live.ot)  : live.ot;
            end else begin
                flags_d = chan_flags_t'(flags_q | live);
            end
        end
    end

    // Flag register.
    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

endmodule

// File: rtl/diag_word_enc.sv
// Registers the 8-bit diagnosis word from the next-state flags so that the
// word changes at the same edge as the flags. Reset value is all ones.
// Assumes two channels (codes at bits 3:2 and 5:4).
module diag_word_enc (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  diag_pkg::chan_flags_t [diag_pkg::NCH-1:0] flags_d,
    input  logic                                  warn_d,
    output logic [diag_pkg::WORD_W-1:0]           word_q
);
    import diag_pkg::*;

    logic [WORD_W-1:0] word_d;
    logic [NCH-1:0]    ot_any;

    // Collect the per-channel over-temperature bits for the summary.
    always_comb begin
        for (int c = 0; c < NCH; c++) ot_any[c] = flags_d[c].ot;
    end

    // Assemble the word: pad bits, channel codes, summary, IC warning.
    always_comb begin
        word_d = '1;
        for (int c = 0; c < NCH; c++) word_d[2 + 2*c +: 2] = pick_code(flags_d[c]);
        word_d[1] = |ot_any;
        word_d[0] = warn_d;
    end

    // Word register.
    always_ff @(posedge clk) begin
        if (!rst_n) word_q <= '1;
        else        word_q <= word_d;
    end

endmodule

// File: rtl/diag_encoder.sv
// Fault filter and diagnosis encoder for a two-channel low-side driver.
// Filters short to ground, open load and overload per channel, passes
// over-temperature straight through, and reports either on unlatched
// status pins or through latched flags, an active-low fault pin and the
// diagnosis word. Inputs are assumed synchronous to clk.
module diag_encoder #(
    parameter int unsigned FILT_CYCLES = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sleep,
    input  logic       serial_mode,
    input  logic       clr_stb,
    input  logic       ovl_latch,
    input  logic       ot_latch,
    input  logic [1:0] ch_cmd,
    input  logic [1:0] raw_sg,
    input  logic [1:0] raw_ol,
    input  logic [1:0] raw_ovl,
    input  logic [1:0] raw_ot,
    input  logic       ic_warn,
    output logic [1:0] status_o,
    output logic       fault_n,
    output logic [7:0] diag_word
);
    import diag_pkg::*;

    chan_flags_t [NCH-1:0] live;
    chan_flags_t [NCH-1:0] flags_q;
    chan_flags_t [NCH-1:0] flags_d;
    logic        [NCH-1:0] live_any;
    logic        [NCH-1:0] held_any;
    logic        [NCH-1:0] sg_filt;
    logic        [NCH-1:0] ot_flag_q;
    logic                  warn_q;
    logic                  warn_d;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic [NFILT-1:0] raw_bus;
        logic [NFILT-1:0] filt_bus;

        assign raw_bus = {raw_ovl[c], raw_ol[c], raw_sg[c]};

        for (genvar k = 0; k < NFILT; k++) begin : g_filt
            fault_filter #(.FILT_CYCLES(FILT_CYCLES)) u_filt (
                .clk   (clk),
                .rst_n (rst_n),
                .quiet (sleep),
                .raw   (raw_bus[k]),
                .filt  (filt_bus[k])
            );
        end

        // Live fault bundle: filtered kinds plus unfiltered over-temperature.
        always_comb begin
            live[c].sg  = filt_bus[0];
            live[c].ol  = filt_bus[1];
            live[c].ovl = filt_bus[2];
            live[c].ot  = raw_ot[c] && !sleep;
        end

        chan_flags u_flags (
            .clk         (clk),
            .rst_n       (rst_n),
            .freeze      (sleep),
            .clr         (clr_stb),
            .cmd         (ch_cmd[c]),
            .ovl_latched (ovl_latch),
            .ot_latched  (ot_latch),
            .live        (live[c]),
            .flags_q     (flags_q[c]),
            .flags_d     (flags_d[c])
        );

        assign live_any[c]  = |live[c];
        assign held_any[c]  = |flags_q[c];
        assign sg_filt[c]   = filt_bus[0];
        assign ot_flag_q[c] = flags_q[c].ot;
    end

    // IC warning flag: same accumulate and clear rules as a channel flag.
    always_comb begin
        if (sleep)        warn_d = warn_q;
        else if (clr_stb) warn_d = ic_warn;
        else              warn_d = warn_q | ic_warn;
    end

    // IC warning flag register.
    always_ff @(posedge clk) begin
        if (!rst_n) warn_q <= 1'b0;
        else        warn_q <= warn_d;
    end

    diag_word_enc u_word (
        .clk     (clk),
        .rst_n   (rst_n),
        .flags_d (flags_d),
        .warn_d  (warn_d),
        .word_q  (diag_word)
    );

    // Status pins: follow the command, invert on a live fault, silent otherwise.
    always_comb begin
        for (int c = 0; c < NCH; c++)
            status_o[c] = !sleep && !serial_mode && (ch_cmd[c] ^ live_any[c]);
    end

    // Fault pin: active low while any channel flag is held in serial mode.
    assign fault_n = !(serial_mode && !sleep && (|held_any));

endmodule

// File: rtl/diag_encoder_chk.sv
// Property checker for diag_encoder, attached with bind below.
module diag_encoder_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sleep,
    input logic       serial_mode,
    input logic       clr_stb,
    input logic       ot_latch,
    input logic [1:0] ch_cmd,
    input logic [1:0] raw_sg,
    input logic [1:0] raw_ot,
    input logic [1:0] sg_filt,
    input logic [1:0] ot_flag,
    input logic [1:0] status_o,
    input logic       fault_n,
    input logic [7:0] diag_word
);
    assert_sleep_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> (fault_n && status_o == 2'b00));

    assert_pad_bits_R5: assert property (@(posedge clk) disable iff (!rst_n)
        diag_word[7:6] == 2'b11);

    assert_fault_pin_mode_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !serial_mode |-> fault_n);

    for (genvar c = 0; c < 2; c++) begin : g_chk
        assert_filter_needs_raw_R2: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(sg_filt[c]) |-> $past(raw_sg[c]));

        assert_ot_unfiltered_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (!sleep && raw_ot[c]) |=> ot_flag[c]);

        assert_clear_blocked_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_stb && !sleep && ot_latch && ch_cmd[c] && ot_flag[c]) |=> ot_flag[c]);
    end

endmodule

bind diag_encoder diag_encoder_chk i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sleep       (sleep),
    .serial_mode (serial_mode),
    .clr_stb     (clr_stb),
    .ot_latch    (ot_latch),
    .ch_cmd      (ch_cmd),
    .raw_sg      (raw_sg),
    .raw_ot      (raw_ot),
    .sg_filt     (sg_filt),
    .ot_flag     (ot_flag_q),
    .status_o    (status_o),
    .fault_n     (fault_n),
    .diag_word   (diag_word)
);

// File: tb/test_diag_encoder.sv
`timescale 1ns/1ps
module test_diag_encoder;
    localparam int F = 16;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       sleep, serial_mode, clr_stb, ovl_latch, ot_latch, ic_warn;
    logic [1:0] ch_cmd, raw_sg, raw_ol, raw_ovl, raw_ot;
    logic [1:0] status_o;
    logic       fault_n;
    logic [7:0] diag_word;

    int checks = 0;
    int errors = 0;
    bit cmp_on = 1'b0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    diag_encoder #(.FILT_CYCLES(F)) i_diag_encoder (
        .clk(clk), .rst_n(rst_n), .sleep(sleep), .serial_mode(serial_mode),
        .clr_stb(clr_stb), .ovl_latch(ovl_latch), .ot_latch(ot_latch),
        .ch_cmd(ch_cmd), .raw_sg(raw_sg), .raw_ol(raw_ol), .raw_ovl(raw_ovl),
        .raw_ot(raw_ot), .ic_warn(ic_warn), .status_o(status_o),
        .fault_n(fault_n), .diag_word(diag_word)
    );

    // ---------------- bench model built from the requirements ----------------
    int       m_cnt [2][3];
    bit [1:0] m_sg, m_ol, m_ovl, m_ot;
    bit       m_warn;
    bit [7:0] m_word;

    function automatic bit raw_of(int c, int k);
        case (k)
            0: return raw_sg[c];
            1: return raw_ol[c];
            default: return raw_ovl[c];
        endcase
    endfunction

    function automatic bit [1:0] code_of(int c);
        if (m_ovl[c] || m_ot[c]) return 2'b10;
        if (m_sg[c])             return 2'b00;
        if (m_ol[c])             return 2'b01;
        return 2'b11;
    endfunction

    function automatic bit exp_status(int c);
        bit lv;
        lv = (m_cnt[c][0] == F) || (m_cnt[c][1] == F) || (m_cnt[c][2] == F) ||
             (raw_ot[c] && !sleep);
        return !sleep && !serial_mode && (ch_cmd[c] ^ lv);
    endfunction

    function automatic bit exp_fault_n();
        return !(serial_mode && !sleep && ((|m_sg) || (|m_ol) || (|m_ovl) || (|m_ot)));
    endfunction

    always @(posedge clk) begin : model
        bit f [3];
        if (!rst_n) begin
            foreach (m_cnt[i, j]) m_cnt[i][j] = 0;
            m_sg = '0; m_ol = '0; m_ovl = '0; m_ot = '0; m_warn = 1'b0;
            m_word = 8'hFF;
        end else begin
            for (int c = 0; c < 2; c++) begin
                for (int k = 0; k < 3; k++) f[k] = (m_cnt[c][k] == F);
                if (!sleep) begin
                    if (clr_stb) begin
                        m_sg[c]  = f[0];
                        m_ol[c]  = f[1];
                        m_ovl[c] = (ovl_latch && ch_cmd[c]) ? (m_ovl[c] | f[2]) : f[2];
                        m_ot[c]  = (ot_latch && ch_cmd[c]) ? (m_ot[c] | raw_ot[c]) : raw_ot[c];
                    end else begin
                        m_sg[c]  = m_sg[c]  | f[0];
                        m_ol[c]  = m_ol[c]  | f[1];
                        m_ovl[c] = m_ovl[c] | f[2];
                        m_ot[c]  = m_ot[c]  | raw_ot[c];
                    end
                end
                for (int k = 0; k < 3; k++)
                    m_cnt[c][k] = (sleep || !raw_of(c, k)) ? 0 :
                                  (m_cnt[c][k] < F ? m_cnt[c][k] + 1 : F);
            end
            if (!sleep) m_warn = clr_stb ? ic_warn : (m_warn | ic_warn);
            m_word = {2'b11, code_of(1), code_of(0), |m_ot, m_warn};
        end
    end

    // ---------------- checking ----------------
    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // Every-cycle comparison against the model, 2 ns after the edge.
    always @(posedge clk) begin
        if (cmp_on && rst_n) begin
            #2;
            chk("R4", "status_o[0]", status_o[0], exp_status(0));
            chk("R4", "status_o[1]", status_o[1], exp_status(1));
            chk("R7", "fault_n", fault_n, exp_fault_n());
            chk("R5", "diag_word", diag_word, m_word);
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic pulse_clr();
        clr_stb = 1'b1;
        step(1);
        clr_stb = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #(5.0 * 150000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; sleep = 1'b0; serial_mode = 1'b0; clr_stb = 1'b0;
        ovl_latch = 1'b0; ot_latch = 1'b0; ic_warn = 1'b0;
        ch_cmd = '0; raw_sg = '0; raw_ol = '0; raw_ovl = '0; raw_ot = '0;
        step(3);
        // R1: reset state
        chk("R1", "word in reset", diag_word, 8'hFF);
        chk("R1", "fault_n in reset", fault_n, 1);
        rst_n = 1'b1;
        cmp_on = 1'b1;
        step(1);
        chk("R1", "word after reset", diag_word, 8'hFC);

        // R2: a pulse one edge short of the window is ignored
        serial_mode = 1'b1;
        raw_sg[0] = 1'b1; step(F - 1);
        raw_sg[0] = 1'b0; step(2);
        chk("R2", "short pulse word", diag_word, 8'hFC);
        chk("R2", "short pulse fault_n", fault_n, 1);
        // R2: a full window is recognized, flag at the following edge
        raw_sg[0] = 1'b1; step(F + 1);
        chk("R2", "sg recognized", diag_word, 8'hF0);
        chk("R7", "fault_n low", fault_n, 0);
        raw_sg[0] = 1'b0; step(3);
        chk("R7", "flag held after fault", diag_word, 8'hF0);
        pulse_clr();
        chk("R8", "cleared", diag_word, 8'hFC);
        chk("R8", "fault_n released", fault_n, 1);

        // R3: over-temperature sets its flag at the next edge
        raw_ot[1] = 1'b1; step(1);
        chk("R3", "ot flag", diag_word, 8'hEE);
        pulse_clr();
        chk("R8", "rewrite while present", diag_word, 8'hEE);
        // R9: latched over-temperature ignores clear while commanded on
        raw_ot[1] = 1'b0; ot_latch = 1'b1; ch_cmd[1] = 1'b1;
        pulse_clr();
        chk("R9", "clear refused", diag_word, 8'hEE);
        ch_cmd[1] = 1'b0;
        pulse_clr();
        chk("R9", "clear after off", diag_word, 8'hFC);
        // R9: latched overload
        ovl_latch = 1'b1; ch_cmd[0] = 1'b1;
        raw_ovl[0] = 1'b1; step(F + 1);
        raw_ovl[0] = 1'b0; step(1);
        pulse_clr();
        chk("R9", "ovl clear refused", diag_word, 8'hF8);
        ch_cmd[0] = 1'b0;
        pulse_clr();
        chk("R9", "ovl clear after off", diag_word, 8'hFC);
        ot_latch = 1'b0; ovl_latch = 1'b0;

        // R6: priority
        raw_sg[0] = 1'b1; raw_ovl[0] = 1'b1; step(F + 1);
        chk("R6", "ovl over sg", diag_word, 8'hF8);
        raw_sg[0] = 1'b0; raw_ovl[0] = 1'b0; step(1);
        pulse_clr();
        raw_sg[1] = 1'b1; raw_ol[1] = 1'b1; step(F + 1);
        chk("R6", "sg over ol", diag_word, 8'hCC);
        raw_sg[1] = 1'b0; raw_ol[1] = 1'b0; step(1);
        pulse_clr();
        // R5: IC warning bit
        ic_warn = 1'b1; step(1);
        chk("R5", "warn bit", diag_word, 8'hFD);
        ic_warn = 1'b0; pulse_clr();

        // R4: status-pin mode
        serial_mode = 1'b0; ch_cmd = 2'b01;
        step(1);
        chk("R4", "follow command", status_o, 2'b01);
        raw_ol[0] = 1'b1; step(F - 1);
        chk("R4", "not yet inverted", status_o, 2'b01);
        step(1);
        chk("R4", "inverted on fault", status_o, 2'b00);
        chk("R7", "fault_n in status mode", fault_n, 1);
        raw_ol[0] = 1'b0; step(1);
        chk("R4", "unlatched", status_o, 2'b01);
        raw_ot[1] = 1'b1; #1;
        chk("R3", "ot inverts at once", status_o, 2'b11);
        @(negedge clk);
        raw_ot[1] = 1'b0; ch_cmd = 2'b00; step(1);
        serial_mode = 1'b1; pulse_clr();

        // R10: sleep
        raw_ot[0] = 1'b1; step(1);
        raw_ot[0] = 1'b0; sleep = 1'b1; ch_cmd = 2'b11; step(1);
        chk("R10", "fault_n in sleep", fault_n, 1);
        chk("R10", "status in sleep", status_o, 2'b00);
        raw_sg[1] = 1'b1; step(F + 3);
        raw_sg[1] = 1'b0; sleep = 1'b0; step(2);
        chk("R10", "sleep fault ignored, flag kept", diag_word, 8'hFA);
        ch_cmd = 2'b00; pulse_clr();
        chk("R10", "cleared after wake", diag_word, 8'hFC);

        // Random phase checked by the model every cycle.
        for (int i = 0; i < 6000; i++) begin
            if (i % 600 == 0) serial_mode = $urandom_range(0, 1);
            if ($urandom_range(0, 19) == 0) raw_sg[$urandom_range(0, 1)] ^= 1'b1;
            if ($urandom_range(0, 19) == 0) raw_ol[$urandom_range(0, 1)] ^= 1'b1;
            if ($urandom_range(0, 19) == 0) raw_ovl[$urandom_range(0, 1)] ^= 1'b1;
            if ($urandom_range(0, 29) == 0) raw_ot[$urandom_range(0, 1)] ^= 1'b1;
            if ($urandom_range(0, 14) == 0) ch_cmd[$urandom_range(0, 1)] ^= 1'b1;
            if ($urandom_range(0, 99) == 0) ovl_latch = ~ovl_latch;
            if ($urandom_range(0, 99) == 0) ot_latch = ~ot_latch;
            if ($urandom_range(0, 149) == 0) sleep = ~sleep;
            ic_warn = ($urandom_range(0, 49) == 0);
            clr_stb = ($urandom_range(0, 11) == 0);
            step(1);
        end

        cmp_on = 1'b0;
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule